// File: doc/BRIEF.md
# Asynchronous SRAM Write Sequencer

This block turns one write request into the control-pin waveform for an external asynchronous static memory (SRAM, PSRAM or NOR-type part). Each write runs as a fixed order of phases: address setup, address hold (multiplexed bus only), data, data hold and bus turnaround. The length of every phase comes from a timing field given in system-clock cycles. The requester presents an address, a data word, a flag selecting the shared address/data bus form and the five timing fields. It then waits for the ready handshake.

Once a request is accepted, the block captures the address, the data, the mode and all the timing fields. Later changes on those inputs do not affect the write in progress. Chip select is released for the whole turnaround phase, so it always toggles between two writes that follow each other directly. A request that arrives during turnaround waits until the block is idle again. A one-cycle done pulse marks the end of the driven part of the write.

Top module: `asram_wr_seq`

## Requirements
- R1: After reset, chip select, write enable and the address-valid strobe are high, the bus output enable is low, ready is high and done is low.
- R2: In the plain (non-multiplexed) bus form, the address setup phase lasts exactly the setup field value in cycles, 0 to 15. A value of 0 starts the data phase in the first cycle after acceptance. This phase is seen on the pins as chip select low with write enable high and the bus not driven.
- R3: In the multiplexed form, the setup phase lasts the setup field value, but never less than 1 cycle. A programmed 0 gives 1 cycle.
- R4: The address hold phase exists only in the multiplexed form. It lasts the hold field value in cycles, and a value of 0 is treated as 1. In the plain form it takes no cycles.
- R5: The data phase lasts the data field value in cycles (1 to 255, with 0 treated as 1). Write enable is low in exactly these cycles and in no others.
- R6: The data hold phase lasts the 2-bit hold field plus one, so 1 to 4 cycles. During it write enable is high and chip select stays low.
- R7: The turnaround phase lasts the 4-bit turnaround field plus one, so 1 to 16 cycles. During it chip select is high and ready is low, and a pending request is not accepted until turnaround has ended.
- R8: Chip select is low from the first setup cycle to the last data hold cycle. It is high for at least one cycle between any two writes, including back-to-back writes.
- R9: In the multiplexed form the shared bus carries the low address bits during setup and hold, and the data word during the data and data hold phases. In the plain form the bus is driven only during the data and data hold phases. The output enable is low in turnaround and idle.
- R10: The address-valid strobe is low only during the setup phase of a multiplexed write. It is high at all other times, and always high in the plain form.
- R11: The address, data, mode and timing fields are captured when a request is accepted. The address output holds the captured address while chip select is low, and later input changes do not affect the write in progress.
- R12: Done is high for exactly one cycle: the first turnaround cycle of each write.
- R13: Ready is high only in the idle state. A request is accepted on a clock edge where both the request and ready are high, and each accepted request produces exactly one write.

Top module ports, in port-list order:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request |
| req_ready | output | 1 | Block idle, request will be accepted |
| req_addr | input | AW | Write address |
| req_data | input | DW | Write data |
| req_mux | input | 1 | 1 = address/data multiplexed bus form |
| cfg_setup | input | SU_W | Address setup cycles |
| cfg_hold | input | HD_W | Address hold cycles (multiplexed only) |
| cfg_data | input | DS_W | Data phase cycles |
| cfg_dhold | input | DH_W | Data hold cycles minus one |
| cfg_turn | input | BT_W | Turnaround cycles minus one |
| done | output | 1 | One-cycle pulse at start of turnaround |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_adv_n | output | 1 | Address-valid strobe, active low |
| mem_addr | output | AW | Address pins |
| mem_ad_out | output | DW | Shared address/data bus output value |
| mem_ad_oe | output | 1 | Bus output enable |

## Verification
The bench targets the clamps and off-by-one encodings. It covers a plain write with a setup of 0, which must skip straight to the data phase, and multiplexed writes with setup, hold and data fields of 0, which a careless design would shorten to zero cycles or extend by wrapping the counter to its maximum. It programs the hold and turnaround fields at both ends of their ranges: treating them as raw counts instead of field plus one shows up as a phase one cycle short. Back-to-back requests, with the next request already waiting during turnaround, catch a design that keeps chip select low between writes or accepts early. The timing inputs are changed right after each acceptance to expose a design that reads them live.

// File: rtl/asram_wr_pkg.sv
package asram_wr_pkg;

    // Counter width wide enough for the longest phase (255 data cycles)
    localparam int LEN_W = 9;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_HOLD,
        PH_DATA,
        PH_DHOLD,
        PH_TURN
    } phase_e;

    // Effective phase lengths in cycles, already clamped and decoded
    typedef struct packed {
        logic [LEN_W-1:0] setup;
        logic [LEN_W-1:0] hold;
        logic [LEN_W-1:0] data;
        logic [LEN_W-1:0] dhold;
        logic [LEN_W-1:0] turn;
    } plan_t;

endpackage

// File: rtl/asram_wr_plan.sv
module asram_wr_plan
    import asram_wr_pkg::*;
#(
    parameter int SU_W = 4,
    parameter int HD_W = 4,
    parameter int DS_W = 8,
    parameter int DH_W = 2,
    parameter int BT_W = 4
) (
    input  logic            mux,
    input  logic [SU_W-1:0] f_setup,
    input  logic [HD_W-1:0] f_hold,
    input  logic [DS_W-1:0] f_data,
    input  logic [DH_W-1:0] f_dhold,
    input  logic [BT_W-1:0] f_turn,
    output plan_t           plan
);

    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    always_comb begin
        // setup: raw count, floor of one on the shared bus
        plan.setup = LEN_W'(f_setup);
        if (mux && (f_setup == '0)) begin
            plan.setup = ONE;
        end
        // hold: multiplexed form only, zero read as one
        if (!mux) begin
            plan.hold = '0;
        end else if (f_hold == '0) begin
            plan.hold = ONE;
        end else begin
            plan.hold = LEN_W'(f_hold);
        end
        // data: zero read as one
        plan.data  = (f_data == '0) ? ONE : LEN_W'(f_data);
        // field-plus-one encodings
        plan.dhold = LEN_W'(f_dhold) + ONE;
        plan.turn  = LEN_W'(f_turn) + ONE;
    end

endmodule

// File: rtl/asram_wr_fsm.sv
module asram_wr_fsm
    import asram_wr_pkg::*;
#(
    parameter int AW = 20,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_data,
    input  logic          req_mux,
    input  plan_t         plan_in,
    output phase_e        phase,
    output logic [AW-1:0] cur_addr,
    output logic [DW-1:0] cur_data,
    output logic          cur_mux,
    output logic          ready,
    output logic          done
);

    typedef struct packed {
        phase_e           phase;
        logic [LEN_W-1:0] cnt;
        plan_t            plan;
        logic [AW-1:0]    addr;
        logic [DW-1:0]    data;
        logic             mux;
        logic             done;
    } st_t;

    localparam st_t RST_ST = '{
        phase: PH_IDLE,
        cnt:   '0,
        plan:  '0,
        addr:  '0,
        data:  '0,
        mux:   1'b0,
        done:  1'b0
    };

    st_t q, d;

    function automatic phase_e next_of(phase_e p, logic m);
        case (p)
            PH_SETUP: return m ? PH_HOLD : PH_DATA;
            PH_HOLD:  return PH_DATA;
            PH_DATA:  return PH_DHOLD;
            PH_DHOLD: return PH_TURN;
            default:  return PH_IDLE;
        endcase
    endfunction

    function automatic logic [LEN_W-1:0] len_of(phase_e p, plan_t pl);
        case (p)
            PH_SETUP: return pl.setup;
            PH_HOLD:  return pl.hold;
            PH_DATA:  return pl.data;
            PH_DHOLD: return pl.dhold;
            PH_TURN:  return pl.turn;
            default:  return LEN_W'(1);
        endcase
    endfunction

    always_comb begin
        phase_e nxt;
        d      = q;
        d.done = 1'b0;
        nxt    = PH_IDLE;
        if (q.phase == PH_IDLE) begin
            if (req_valid) begin
                d.plan = plan_in;
                d.addr = req_addr;
                d.data = req_data;
                d.mux  = req_mux;
                if (plan_in.setup != '0) begin
                    d.phase = PH_SETUP;
                    d.cnt   = plan_in.setup - LEN_W'(1);
                end else begin
                    d.phase = PH_DATA;
                    d.cnt   = plan_in.data - LEN_W'(1);
                end
            end
        end else if (q.cnt == '0) begin
            nxt     = next_of(q.phase, q.mux);
            d.phase = nxt;
            d.cnt   = (nxt == PH_IDLE) ? '0 : len_of(nxt, q.plan) - LEN_W'(1);
            d.done  = (nxt == PH_TURN);
        end else begin
            d.cnt = q.cnt - LEN_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= RST_ST;
        end else begin
            q <= d;
        end
    end

    assign phase    = q.phase;
    assign cur_addr = q.addr;
    assign cur_data = q.data;
    assign cur_mux  = q.mux;
    assign ready    = (q.phase == PH_IDLE);
    assign done     = q.done;

endmodule

// File: rtl/asram_wr_pins.sv
module asram_wr_pins
    import asram_wr_pkg::*;
#(
    parameter int AW = 20,
    parameter int DW = 16
) (
    input  phase_e        phase,
    input  logic          mux,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] data,
    output logic          cs_n,
    output logic          we_n,
    output logic          adv_n,
    output logic [AW-1:0] pin_addr,
    output logic [DW-1:0] ad_out,
    output logic          ad_oe
);

    logic active, addr_ph, data_ph;

    always_comb begin
        active   = (phase == PH_SETUP) || (phase == PH_HOLD) ||
                   (phase == PH_DATA)  || (phase == PH_DHOLD);
        addr_ph  = (phase == PH_SETUP) || (phase == PH_HOLD);
        data_ph  = (phase == PH_DATA)  || (phase == PH_DHOLD);
        cs_n     = !active;
        we_n     = (phase != PH_DATA);
        adv_n    = !(mux && (phase == PH_SETUP));
        pin_addr = active ? addr : '0;
        ad_oe    = data_ph || (mux && addr_ph);
        if (data_ph) begin
            ad_out = data;
        end else if (mux && addr_ph) begin
            ad_out = DW'(addr);
        end else begin
            ad_out = '0;
        end
    end

endmodule

// File: rtl/asram_wr_seq.sv
module asram_wr_seq
    import asram_wr_pkg::*;
#(
    parameter int AW   = 20,
    parameter int DW   = 16,
    parameter int SU_W = 4,
    parameter int HD_W = 4,
    parameter int DS_W = 8,
    parameter int DH_W = 2,
    parameter int BT_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [AW-1:0]   req_addr,
    input  logic [DW-1:0]   req_data,
    input  logic            req_mux,
    input  logic [SU_W-1:0] cfg_setup,
    input  logic [HD_W-1:0] cfg_hold,
    input  logic [DS_W-1:0] cfg_data,
    input  logic [DH_W-1:0] cfg_dhold,
    input  logic [BT_W-1:0] cfg_turn,
    output logic            done,
    output logic            mem_cs_n,
    output logic            mem_we_n,
    output logic            mem_adv_n,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_ad_out,
    output logic            mem_ad_oe
);

    plan_t         plan;
    phase_e        phase;
    logic [AW-1:0] cur_addr;
    logic [DW-1:0] cur_data;
    logic          cur_mux;

    asram_wr_plan #(
        .SU_W(SU_W), .HD_W(HD_W), .DS_W(DS_W), .DH_W(DH_W), .BT_W(BT_W)
    ) u_plan (
        .mux     (req_mux),
        .f_setup (cfg_setup),
        .f_hold  (cfg_hold),
        .f_data  (cfg_data),
        .f_dhold (cfg_dhold),
        .f_turn  (cfg_turn),
        .plan    (plan)
    );

    asram_wr_fsm #(.AW(AW), .DW(DW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_data  (req_data),
        .req_mux   (req_mux),
        .plan_in   (plan),
        .phase     (phase),
        .cur_addr  (cur_addr),
        .cur_data  (cur_data),
        .cur_mux   (cur_mux),
        .ready     (req_ready),
        .done      (done)
    );

    asram_wr_pins #(.AW(AW), .DW(DW)) u_pins (
        .phase    (phase),
        .mux      (cur_mux),
        .addr     (cur_addr),
        .data     (cur_data),
        .cs_n     (mem_cs_n),
        .we_n     (mem_we_n),
        .adv_n    (mem_adv_n),
        .pin_addr (mem_addr),
        .ad_out   (mem_ad_out),
        .ad_oe    (mem_ad_oe)
    );

endmodule

// File: rtl/asram_wr_seq_chk.sv
module asram_wr_seq_chk #(
    parameter int AW = 20,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic          done,
    input logic          mem_cs_n,
    input logic          mem_we_n,
    input logic          mem_adv_n,
    input logic [AW-1:0] mem_addr,
    input logic          mem_ad_oe
);

    AST_WE_ONLY_WITH_CS: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !mem_cs_n && mem_ad_oe);                        // R5
    AST_CS_FALL_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_cs_n) |-> $past(req_valid && req_ready));           // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> mem_cs_n && mem_we_n && !mem_ad_oe && !done);   // R13
    AST_ADV_IN_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_adv_n |-> !mem_cs_n && mem_ad_oe && mem_we_n);           // R10
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                              // R12
    AST_DONE_IN_TURN: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> mem_cs_n && !req_ready && $past(!mem_cs_n));         // R12
    AST_BUS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_cs_n) |-> !mem_ad_oe);                              // R9
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));       // R11

endmodule

bind asram_wr_seq asram_wr_seq_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .done      (done),
    .mem_cs_n  (mem_cs_n),
    .mem_we_n  (mem_we_n),
    .mem_adv_n (mem_adv_n),
    .mem_addr  (mem_addr),
    .mem_ad_oe (mem_ad_oe)
);

// File: tb/asram_wr_seq_bench.sv
module asram_wr_seq_bench;

    localparam int AW = 20;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic          req_mux = 1'b0;
    logic [3:0]    cfg_setup = '0;
    logic [3:0]    cfg_hold = '0;
    logic [7:0]    cfg_data = '0;
    logic [1:0]    cfg_dhold = '0;
    logic [3:0]    cfg_turn = '0;
    logic          done, mem_cs_n, mem_we_n, mem_adv_n, mem_ad_oe;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_ad_out;

    always #2.5 clk = ~clk;

    asram_wr_seq u_asram_wr_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_data(req_data), .req_mux(req_mux),
        .cfg_setup(cfg_setup), .cfg_hold(cfg_hold), .cfg_data(cfg_data),
        .cfg_dhold(cfg_dhold), .cfg_turn(cfg_turn), .done(done),
        .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_adv_n(mem_adv_n),
        .mem_addr(mem_addr), .mem_ad_out(mem_ad_out), .mem_ad_oe(mem_ad_oe)
    );

    typedef struct {
        int            su, hd, ds, dh, bt;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic          mux;
    } item_t;

    item_t exp_q[$];
    item_t cur;
    int total = 0, bad = 0;
    int sent = 0, seen = 0;
    bit in_acc = 0, seen_data = 0, finished = 0;
    int cnt_su, cnt_hd, cnt_ds, cnt_dh, cnt_bt;
    int bus_err, adv_err, addr_err, done_err;
    int cycles = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Driver: expected lengths follow R2..R7 directly
    task automatic send(input logic [AW-1:0] a, input logic [DW-1:0] dt, input logic m,
                        input int su, input int hd, input int ds, input int dh, input int bt);
        item_t it;
        req_addr  = a;      req_data  = dt;      req_mux  = m;
        cfg_setup = 4'(su); cfg_hold  = 4'(hd);  cfg_data = 8'(ds);
        cfg_dhold = 2'(dh); cfg_turn  = 4'(bt);  req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        it.su   = (m && su == 0) ? 1 : su;
        it.hd   = m ? ((hd == 0) ? 1 : hd) : 0;
        it.ds   = (ds == 0) ? 1 : ds;
        it.dh   = dh + 1;
        it.bt   = bt + 1;
        it.addr = a; it.data = dt; it.mux = m;
        exp_q.push_back(it);
        sent++;
        @(negedge clk);
        // R11: scramble every input right after acceptance
        req_valid = 1'b0;
        req_addr  = ~a;  req_data = ~dt; req_mux = ~m;
        cfg_setup = 4'(su + 5); cfg_hold = 4'(hd + 3); cfg_data = 8'(ds + 7);
        cfg_dhold = 2'(dh + 1); cfg_turn = 4'(bt + 6);
    endtask

    task automatic finish_item();
        chk(cnt_su == cur.su, cur.mux ? "R3 setup" : "R2 setup", cnt_su, cur.su);
        chk(cnt_hd == cur.hd, "R4 hold", cnt_hd, cur.hd);
        chk(cnt_ds == cur.ds, "R5 data", cnt_ds, cur.ds);
        chk(cnt_dh == cur.dh, "R6 data hold", cnt_dh, cur.dh);
        chk(cnt_bt == cur.bt, "R7 turnaround", cnt_bt, cur.bt);
        chk(cnt_bt >= 1, "R8 cs gap", cnt_bt, 1);
        chk(bus_err == 0, "R9 bus", bus_err, 0);
        chk(adv_err == 0, "R10 adv", adv_err, 0);
        chk(addr_err == 0, "R11 addr", addr_err, 0);
        chk(done_err == 0, "R12 done", done_err, 0);
        seen++;
    endtask

    // Monitor: rebuilds the phase lengths from the pins
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (req_ready) begin
                if (in_acc) begin
                    finish_item();
                    in_acc = 0;
                end
            end else begin
                if (!in_acc) begin
                    in_acc = 1; seen_data = 0;
                    cnt_su = 0; cnt_hd = 0; cnt_ds = 0; cnt_dh = 0; cnt_bt = 0;
                    bus_err = 0; adv_err = 0; addr_err = 0; done_err = 0;
                    if (exp_q.size() == 0) begin
                        chk(0, "R13 unexpected write", 1, 0);
                        cur = '{0, 0, 0, 0, 0, '0, '0, 1'b0};
                    end else begin
                        cur = exp_q.pop_front();
                    end
                end
                if (!mem_cs_n) begin
                    if (mem_addr != cur.addr) addr_err++;
                    if (done) done_err++;
                    if (!mem_we_n) begin
                        cnt_ds++; seen_data = 1;
                        if (!mem_ad_oe || mem_ad_out != cur.data || !mem_adv_n) bus_err++;
                    end else if (seen_data) begin
                        cnt_dh++;
                        if (!mem_ad_oe || mem_ad_out != cur.data || !mem_adv_n) bus_err++;
                    end else if (!mem_adv_n) begin
                        cnt_su++;
                        if (!cur.mux) adv_err++;
                        if (!mem_ad_oe || mem_ad_out != DW'(cur.addr)) bus_err++;
                    end else if (mem_ad_oe) begin
                        cnt_hd++;
                        if (mem_ad_out != DW'(cur.addr)) bus_err++;
                    end else begin
                        cnt_su++;
                        if (cur.mux) adv_err++;
                    end
                end else begin
                    if ((cnt_bt == 0) != done) done_err++;
                    if (mem_ad_oe || !mem_adv_n || !mem_we_n) bus_err++;
                    cnt_bt++;
                end
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !finished) begin
            chk(0, "watchdog", cycles, 100000);
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 / R13 reset state
        chk(mem_cs_n == 1'b1, "R1 cs_n", mem_cs_n, 1);
        chk(mem_we_n == 1'b1, "R1 we_n", mem_we_n, 1);
        chk(mem_adv_n == 1'b1, "R1 adv_n", mem_adv_n, 1);
        chk(mem_ad_oe == 1'b0, "R1 oe", mem_ad_oe, 0);
        chk(done == 1'b0, "R1 done", done, 0);
        chk(req_ready == 1'b1, "R13 ready", req_ready, 1);

        send(20'h1A5C3, 16'hBEEF, 1'b0, 3, 5, 4, 1, 2);     // plain, hold ignored
        repeat (4) @(negedge clk);
        send(20'h00F0F, 16'h1234, 1'b0, 0, 0, 1, 0, 0);     // R2 zero setup
        repeat (3) @(negedge clk);
        send(20'h2C001, 16'hA55A, 1'b1, 0, 2, 3, 3, 15);    // R3 clamp
        repeat (2) @(negedge clk);
        send(20'h3FFFF, 16'h0F0F, 1'b1, 2, 0, 0, 2, 0);     // R4/R5 zero clamp
        // back-to-back, next request waits through turnaround (R7, R8)
        send(20'h11111, 16'h2222, 1'b1, 1, 1, 2, 0, 3);
        send(20'h33333, 16'h4444, 1'b0, 2, 9, 2, 1, 0);
        send(20'h55555, 16'h6666, 1'b1, 4, 3, 1, 3, 1);
        repeat (2) @(negedge clk);
        send(20'h7ABCD, 16'hC3C3, 1'b1, 15, 15, 255, 3, 15); // maxima
        while (exp_q.size() != 0 || in_acc) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(seen == sent, "R13 one write per accept", seen, sent);
        chk(req_ready == 1'b1 && mem_cs_n == 1'b1, "R13 idle after", req_ready, 1);
        report();
    end

endmodule